// File: doc/BRIEF.md
# Timerless Step-Rate Indexer

This block turns a reference velocity into discrete step pulses for a stepper motor drive. It needs no reload timer for each motor. Time since the last step is kept as a whole number `k` of fixed-length iterations. Each iteration, one sequential shift-and-add multiplier forms `k * velocity`. When that product first reaches a constant threshold, the block issues a step. The threshold equals the number of iterations per second. This replaces the division `1 / velocity` with one multiply and one compare.

After a step, `k` restarts from one. The pulse goes both to the profile generator, which supplies the next velocity, and to the phase sequencer. Because `k` is an integer, the step period is quantized to whole iterations. Velocities that round to the same `k` give identical step rates. Profile calculation and phase sequencing sit outside this block.

Top module: `stepidx_top`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `step_o` and `busy_o` are low. The iteration count starts at 1, so the first step after enabling at constant velocity `v` follows the same rule as R3.
- R2: With `enable_i` held high, one iteration lasts `VEL_W+2` clock cycles. `busy_o` is low for one cycle at the start of each iteration and high for the remaining `VEL_W+1` cycles. Exactly one multiplication is performed per iteration.
- R3: For a constant velocity `v > 0`, a step is issued at the end of the first iteration whose count `k` satisfies `k * v >= THRESH`. Rising edges of `step_o` are therefore `ceil(THRESH / v) * (VEL_W+2)` cycles apart, provided that count does not exceed `2^CNT_W - 1`.
- R4: `step_o` is high for exactly one clock cycle per step. That cycle is the low-`busy_o` cycle in which the next iteration starts.
- R5: After a step, the count restarts at 1. The interval that follows depends only on the velocity presented from the step cycle onward.
- R6: A velocity of zero never produces a step.
- R7: The count `k` saturates at `2^CNT_W - 1` and never wraps. After a long run at a velocity too low to step, raising the velocity so that `(2^CNT_W - 1) * v >= THRESH` yields a step within two iterations.
- R8: While `enable_i` is low, no new iteration starts. `busy_o` falls once the iteration in progress has finished, no step is issued, and `k` is held. On re-enable, counting resumes from the held value.
- R9: The velocity is sampled once, in the cycle an iteration starts. A change during the multiply takes effect at the next iteration.
- R10: The step period is quantized to whole iterations. Two velocities with equal `ceil(THRESH / v)` produce identical step intervals. Velocities on either side of a boundary `THRESH / k` differ by exactly one iteration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable_i | input | 1 | Allows new iterations to start |
| vel_i | input | VEL_W | Reference velocity, in steps per second |
| step_o | output | 1 | One-cycle step pulse |
| busy_o | output | 1 | High while an iteration's multiply/compare is in progress |

## Verification
The bench builds the block with `VEL_W=16`, `CNT_W=8` and `THRESH=1000`. This keeps the 18-cycle iteration while making a full step interval at most 255 iterations long. Count saturation then becomes reachable within a few thousand cycles. Velocity boundaries such as 499/500 and 333/334 also fall on small, hand-checkable counts. Random velocities cover both the multi-iteration range below the threshold and the single-iteration range above it.

// File: rtl/stepidx_pkg.sv
package stepidx_pkg;

    typedef enum logic {
        ST_LOAD = 1'b0,
        ST_WAIT = 1'b1
    } idx_state_e;

    // Saturating increment on a 32-bit container; the caller supplies the limit
    function automatic logic [31:0] sat_inc(input logic [31:0] val, input logic [31:0] lim);
        return (val >= lim) ? lim : val + 32'd1;
    endfunction

endpackage

// File: rtl/stepidx_mul.sv
module stepidx_mul #(
    parameter int A_W = 16,
    parameter int B_W = 16,
    parameter int P_W = A_W + B_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [A_W-1:0] a,
    input  logic [B_W-1:0] b,
    output logic           busy,
    output logic           done,
    output logic [P_W-1:0] prod
);
    localparam int BN_W = $clog2(B_W + 1);

    logic [P_W-1:0]  mcand;
    logic [B_W-1:0]  mplier;
    logic [A_W-1:0]  a_q;
    logic [B_W-1:0]  b_q;
    logic [BN_W-1:0] bitn;

    always_ff @(posedge clk) begin
        if (rst) begin
            mcand  <= '0;
            mplier <= '0;
            a_q    <= '0;
            b_q    <= '0;
            bitn   <= '0;
            prod   <= '0;
            busy   <= 1'b0;
            done   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !busy) begin
                mcand  <= P_W'(a);
                mplier <= b;
                a_q    <= a;
                b_q    <= b;
                prod   <= '0;
                bitn   <= '0;
                busy   <= 1'b1;
            end else if (busy) begin
                if (mplier[0]) prod <= prod + mcand;
                mcand  <= mcand << 1;
                mplier <= mplier >> 1;
                bitn   <= bitn + 1'b1;
                if (bitn == BN_W'(B_W - 1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    AST_MUL_RESULT: assert property (@(posedge clk) disable iff (rst)
        done |-> prod == (P_W'(a_q) * P_W'(b_q)));  // R3
    AST_ZERO_PRODUCT: assert property (@(posedge clk) disable iff (rst)
        (done && b_q == '0) |-> prod == '0);  // R6
    AST_ONE_MUL: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);  // R2

endmodule

// File: rtl/stepidx_kcnt.sv
module stepidx_kcnt
    import stepidx_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             adv,
    output logic [CNT_W-1:0] k
);
    localparam logic [CNT_W-1:0] KMAX = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clr) k <= CNT_W'(1);
        else if (adv)   k <= CNT_W'(sat_inc(32'(k), 32'(KMAX)));
    end

    AST_K_SATURATE: assert property (@(posedge clk) disable iff (rst)
        (adv && !clr && k == KMAX) |=> k == KMAX);  // R7
    AST_K_NONZERO: assert property (@(posedge clk) disable iff (rst)
        k != '0);  // R7

endmodule

// File: rtl/stepidx_top.sv
module stepidx_top
    import stepidx_pkg::*;
#(
    parameter int          VEL_W  = 16,
    parameter int          CNT_W  = 16,
    parameter int unsigned THRESH = 2500000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable_i,
    input  logic [VEL_W-1:0] vel_i,
    output logic             step_o,
    output logic             busy_o
);
    localparam int PROD_W = VEL_W + CNT_W;
    localparam logic [PROD_W-1:0] THR = PROD_W'(THRESH);

    idx_state_e        state;
    logic              start, hit;
    logic              mul_busy, mul_done;
    logic [PROD_W-1:0] mul_prod;
    logic [CNT_W-1:0]  k;

    assign start  = (state == ST_LOAD) && enable_i;
    assign hit    = mul_prod >= THR;
    assign busy_o = (state == ST_WAIT);

    stepidx_mul #(.A_W(CNT_W), .B_W(VEL_W), .P_W(PROD_W)) i_mul (
        .clk(clk), .rst(rst), .start(start), .a(k), .b(vel_i),
        .busy(mul_busy), .done(mul_done), .prod(mul_prod)
    );

    stepidx_kcnt #(.CNT_W(CNT_W)) i_kcnt (
        .clk(clk), .rst(rst),
        .clr(mul_done && hit), .adv(mul_done && !hit), .k(k)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_LOAD;
            step_o <= 1'b0;
        end else begin
            step_o <= 1'b0;
            case (state)
                ST_LOAD: if (enable_i) state <= ST_WAIT;
                ST_WAIT: if (mul_done) begin
                    step_o <= hit;
                    state  <= ST_LOAD;
                end
                default: state <= ST_LOAD;
            endcase
        end
    end

    AST_STEP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        step_o |=> !step_o);  // R4
    AST_STEP_AT_LOAD: assert property (@(posedge clk) disable iff (rst)
        step_o |-> !busy_o);  // R4
    AST_K_RESTART: assert property (@(posedge clk) disable iff (rst)
        step_o |-> k == CNT_W'(1));  // R5
    AST_ENABLE_LOW: assert property (@(posedge clk) disable iff (rst)
        (state == ST_LOAD && !enable_i) |=> (!busy_o && !step_o));  // R8
    AST_BUSY_COVER: assert property (@(posedge clk) disable iff (rst)
        mul_busy |-> busy_o);  // R2

endmodule

// File: tb/test_stepidx_top.sv
module test_stepidx_top;
    localparam int VEL_W  = 16;
    localparam int CNT_W  = 8;
    localparam int THRESH = 1000;
    localparam int ITER   = VEL_W + 2;
    localparam int KMAX   = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic enable_i = 1'b0;
    logic [VEL_W-1:0] vel_i = '0;
    logic step_o, busy_o;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    stepidx_top #(.VEL_W(VEL_W), .CNT_W(CNT_W), .THRESH(THRESH)) i_stepidx_top (
        .clk(clk), .rst(rst), .enable_i(enable_i), .vel_i(vel_i),
        .step_o(step_o), .busy_o(busy_o)
    );

    function automatic int exp_interval(input int v);
        int kk;
        if (v == 0) return -1;
        kk = (THRESH + v - 1) / v;
        if (kk > KMAX) return -1;
        return kk * ITER;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Counts negedges until step_o is seen; returns -1 if not seen within lim
    task automatic wait_step(input int lim, output int n);
        n = -1;
        for (int i = 1; i <= lim; i++) begin
            @(negedge clk);
            if (step_o) begin n = i; break; end
        end
    endtask

    task automatic interval_check(input string req, input int v);
        int n;
        vel_i = VEL_W'(v);
        wait_step(KMAX * ITER + 50, n);
        check(req, n, exp_interval(v));
    endtask

    initial begin
        #(150000 * 20);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
        $finish;
    end

    initial begin
        int n, v, busy_cnt;
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        check("R1 step in reset", int'(step_o), 0);
        check("R1 busy in reset", int'(busy_o), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 step after reset", int'(step_o), 0);
        check("R1 busy after reset", int'(busy_o), 0);

        // R1/R3: first step from enable at v=500 -> k=2
        vel_i = 16'd500;
        enable_i = 1'b1;
        wait_step(500, n);
        check("R1 first interval", n, 2 * ITER);

        // R4: single-cycle pulse, busy low during it
        check("R4 busy low with step", int'(busy_o), 0);
        vel_i = 16'd1000;
        @(negedge clk);
        check("R4 step width", int'(step_o), 0);
        // R2: busy high through remainder of the iteration
        busy_cnt = 1;
        for (int i = 0; i < ITER - 2; i++) begin
            @(negedge clk);
            busy_cnt += int'(busy_o);
        end
        check("R2 busy cycles", busy_cnt, ITER - 1);
        wait_step(ITER + 5, n);
        check("R2 iteration length k=1", n, 1);

        // R10: quantization boundaries
        interval_check("R10 v=1000", 1000);
        interval_check("R10 v=999", 999);
        interval_check("R10 v=500", 500);
        interval_check("R10 v=499", 499);
        interval_check("R10 v=334", 334);
        interval_check("R10 v=333", 333);
        interval_check("R10 v=400", 400);

        // R9: velocity change mid-iteration applies next iteration
        vel_i = 16'd50;
        repeat (5) @(negedge clk);
        vel_i = 16'd1000;
        wait_step(200, n);
        check("R9 sampled at iteration start", n, 2 * ITER - 5);

        // R3/R5: random velocities
        for (int t = 0; t < 20; t++) begin
            if ($urandom % 2) v = 4 + int'($urandom % 996);
            else              v = 1000 + int'($urandom % 64536);
            interval_check("R3 random", v);
        end

        // R8: pause mid-interval keeps k
        vel_i = 16'd100;
        wait_step(300, n);
        check("R5 restart interval v=100", n, 10 * ITER);
        repeat (4 * ITER + ITER / 2) @(negedge clk);
        enable_i = 1'b0;
        repeat (ITER + 2) @(negedge clk);
        check("R8 busy low when disabled", int'(busy_o), 0);
        wait_step(400, n);
        check("R8 no step when disabled", n, -1);
        enable_i = 1'b1;
        wait_step(400, n);
        checks++;
        if (n < 0 || n > 6 * ITER) begin
            errors++;
            $display("FAIL R8 resume: actual %0d expected <= %0d", n, 6 * ITER);
        end

        // R6: zero velocity never steps
        vel_i = '0;
        wait_step(3000, n);
        check("R6 zero velocity", n, -1);

        // R7: saturation at KMAX, then step within two iterations
        vel_i = 16'd1;
        wait_step((KMAX + 10) * ITER, n);
        check("R7 no step at v=1", n, -1);
        vel_i = 16'd4;
        wait_step(2 * ITER + 2, n);
        checks++;
        if (n < 0) begin
            errors++;
            $display("FAIL R7 saturate: actual %0d expected <= %0d", n, 2 * ITER + 2);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule